// File: doc/BRIEF.md
# Branch Target Predictor with Static Fallback and Return Stack

This block is the front-end branch prediction unit. A fetch address is looked up in a direct-mapped target table; each entry holds a valid bit, a partial tag, a target and a 2-bit saturating history counter. When the tag matches, the block reports a hit together with the predicted direction and target one cycle later. When the table has no entry, the decoder later presents the branch address and its signed displacement. The static path then predicts direction from the displacement sign and reports the branch target.

A small circular return-address stack is pushed by calls and popped by returns, and it supplies the predicted return target. The table changes only through update requests from retirement, which carry the resolved target and outcome. The table size is a parameter: twelve index bits gives the full 4K-entry table, and a smaller value is used for verification.

Top module: `branch_oracle`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is 0, and a lookup to any address after reset misses.
- R2: A lookup presented in cycle N reports in cycle N+1: `hit_o`=1 with the stored target when the entry is valid and its tag (address bits above the index) matches; otherwise `hit_o`=0, `pred_taken_o`=0 and `pred_target_o`=0.
- R3: An update that misses allocates the entry with the resolved target and a counter of 2 (weakly taken, predicted taken) if the branch was taken, or 1 (weakly not-taken, predicted not-taken) if it was not taken.
- R4: An update that hits moves the counter one step toward the outcome, saturating at 0 and 3, and stores the resolved target; the direction predicted is taken when the counter is 2 or 3.
- R5: An update to an index whose stored tag differs replaces that entry, so the old address then misses.
- R6: When a lookup and an update hit the same index in one cycle, the lookup reports the entry as it was before the update; the following lookup sees the update.
- R7: A decoded branch in cycle N gives `st_valid_o`=1 in cycle N+1 with `st_target_o` = address + displacement; `st_taken_o`=1 for a negative displacement and 0 for zero or positive.
- R8: Returns pop addresses in last-in first-out order; a pop reports `ras_valid_o`=1 and the address in the next cycle.
- R9: Pushing more than the stack depth overwrites the oldest entry; the most recent DEPTH addresses pop back, then the stack reads as empty.
- R10: A pop on an empty stack gives `ras_err_o`=1, `ras_valid_o`=0 and `ras_target_o`=0 in the next cycle.
- R11: A push and a pop in the same cycle return the current top, and the pushed address takes its place without changing the depth.
- R12: Lookups alone never change the table: a missed address keeps missing until an update is made to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid_i | input | 1 | Fetch lookup request |
| lk_addr_i | input | ADDR_W | Fetch linear address |
| upd_valid_i | input | 1 | Retirement update request |
| upd_addr_i | input | ADDR_W | Address of the retired branch |
| upd_target_i | input | ADDR_W | Resolved target |
| upd_taken_i | input | 1 | Resolved direction |
| dec_valid_i | input | 1 | Decoded branch present |
| dec_addr_i | input | ADDR_W | Address of the decoded branch |
| dec_disp_i | input | ADDR_W | Signed displacement |
| call_push_i | input | 1 | Call: push return address |
| call_ret_addr_i | input | ADDR_W | Return address to push |
| ret_pop_i | input | 1 | Return: pop predicted target |
| hit_o | output | 1 | Table hit |
| pred_taken_o | output | 1 | Predicted direction on hit |
| pred_target_o | output | ADDR_W | Predicted target on hit |
| st_valid_o | output | 1 | Static prediction valid |
| st_taken_o | output | 1 | Static direction |
| st_target_o | output | ADDR_W | Static branch target |
| ras_valid_o | output | 1 | Return prediction valid |
| ras_err_o | output | 1 | Pop on an empty stack |
| ras_target_o | output | ADDR_W | Predicted return address |

## Verification
A corrupt counter shows up as a wrong `pred_taken_o` on the next lookup to that address, one cycle after that lookup. The bench therefore walks a single entry through allocation, saturation and decay. A wrong tag or valid bit shows as a false hit or a false miss at an aliasing address. A stack pointer or occupancy error shows as a wrong address or a wrong empty flag on the first pop after the push sequence that exposes it, which is why overflow and combined push/pop are followed by draining the stack.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_WEAK_NT = 2'd1;
    localparam ctr_t CTR_WEAK_T  = 2'd2;

    function automatic ctr_t ctr_step(ctr_t c, logic taken);
        ctr_t r;
        r = c;
        if (taken && c != 2'd3) r = c + 2'd1;
        if (!taken && c != 2'd0) r = c - 2'd1;
        return r;
    endfunction
endpackage

// File: rtl/btb_table.sv
module btb_table #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [ADDR_W-1:0] up_target,
    input  logic              up_taken,
    output logic              hit,
    output logic              taken,
    output logic [ADDR_W-1:0] target
);
    import bp_pkg::*;

    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] tgt;
        ctr_t              ctr;
    } entry_t;

    typedef struct packed {
        logic              hit;
        logic              taken;
        logic [ADDR_W-1:0] tgt;
    } pred_t;

    entry_t tbl_q [ENTRIES];
    entry_t tbl_d [ENTRIES];
    pred_t  pred_q, pred_d;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    entry_t           lk_ent, up_ent;

    assign lk_idx = lk_addr[IDX_W-1:0];
    assign lk_tag = lk_addr[IDX_W +: TAG_W];
    assign up_idx = up_addr[IDX_W-1:0];
    assign up_tag = up_addr[IDX_W +: TAG_W];
    assign lk_ent = tbl_q[lk_idx];
    assign up_ent = tbl_q[up_idx];

    always_comb begin
        tbl_d  = tbl_q;
        pred_d = '0;
        // lookup reads the registered table, so a same-cycle update is not seen
        if (lk_valid && lk_ent.vld && lk_ent.tag == lk_tag) begin
            pred_d.hit   = 1'b1;
            pred_d.taken = lk_ent.ctr[1];
            pred_d.tgt   = lk_ent.tgt;
        end
        if (up_valid) begin
            if (up_ent.vld && up_ent.tag == up_tag) begin
                tbl_d[up_idx].ctr = ctr_step(up_ent.ctr, up_taken);
                tbl_d[up_idx].tgt = up_target;
            end else begin
                tbl_d[up_idx].vld = 1'b1;
                tbl_d[up_idx].tag = up_tag;
                tbl_d[up_idx].tgt = up_target;
                tbl_d[up_idx].ctr = up_taken ? CTR_WEAK_T : CTR_WEAK_NT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
            pred_q <= '0;
        end else begin
            tbl_q  <= tbl_d;
            pred_q <= pred_d;
        end
    end

    assign hit    = pred_q.hit;
    assign taken  = pred_q.taken;
    assign target = pred_q.tgt;
endmodule

// File: rtl/static_pred.sv
module static_pred #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic [ADDR_W-1:0] dec_addr,
    input  logic [ADDR_W-1:0] dec_disp,
    output logic              st_valid,
    output logic              st_taken,
    output logic [ADDR_W-1:0] st_target
);
    typedef struct packed {
        logic              vld;
        logic              taken;
        logic [ADDR_W-1:0] tgt;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = '0;
        if (dec_valid) begin
            st_d.vld   = 1'b1;
            st_d.taken = dec_disp[ADDR_W-1];
            st_d.tgt   = dec_addr + dec_disp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st_valid  = st_q.vld;
    assign st_taken  = st_q.taken;
    assign st_target = st_q.tgt;
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    output logic              pop_valid,
    output logic              pop_err,
    output logic [ADDR_W-1:0] pop_target
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0]  top;
        logic [CNT_W-1:0]  cnt;
        logic              vld;
        logic              err;
        logic [ADDR_W-1:0] tgt;
    } ctl_t;

    ctl_t              ctl_q, ctl_d;
    logic [ADDR_W-1:0] mem_q [DEPTH];
    logic [ADDR_W-1:0] mem_d [DEPTH];
    logic              pop_ok;

    assign pop_ok = pop && (ctl_q.cnt != '0);

    always_comb begin
        ctl_d     = ctl_q;
        mem_d     = mem_q;
        ctl_d.vld = pop_ok;
        ctl_d.err = pop && !pop_ok;
        ctl_d.tgt = pop_ok ? mem_q[ctl_q.top] : '0;
        if (push && pop_ok) begin
            mem_d[ctl_q.top] = push_addr;
        end else if (push) begin
            ctl_d.top            = ctl_q.top + 1'b1;
            mem_d[ctl_q.top + 1'b1] = push_addr;
            if (ctl_q.cnt != FULL) ctl_d.cnt = ctl_q.cnt + 1'b1;
        end else if (pop_ok) begin
            ctl_d.top = ctl_q.top - 1'b1;
            ctl_d.cnt = ctl_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            ctl_q <= ctl_d;
            mem_q <= mem_d;
        end
    end

    assign pop_valid  = ctl_q.vld;
    assign pop_err    = ctl_q.err;
    assign pop_target = ctl_q.tgt;
endmodule

// File: rtl/branch_oracle.sv
module branch_oracle #(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 10,
    parameter int TAG_W     = 12,
    parameter int RAS_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid_i,
    input  logic [ADDR_W-1:0] lk_addr_i,
    input  logic              upd_valid_i,
    input  logic [ADDR_W-1:0] upd_addr_i,
    input  logic [ADDR_W-1:0] upd_target_i,
    input  logic              upd_taken_i,
    input  logic              dec_valid_i,
    input  logic [ADDR_W-1:0] dec_addr_i,
    input  logic [ADDR_W-1:0] dec_disp_i,
    input  logic              call_push_i,
    input  logic [ADDR_W-1:0] call_ret_addr_i,
    input  logic              ret_pop_i,
    output logic              hit_o,
    output logic              pred_taken_o,
    output logic [ADDR_W-1:0] pred_target_o,
    output logic              st_valid_o,
    output logic              st_taken_o,
    output logic [ADDR_W-1:0] st_target_o,
    output logic              ras_valid_o,
    output logic              ras_err_o,
    output logic [ADDR_W-1:0] ras_target_o
);
    btb_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid_i), .lk_addr(lk_addr_i),
        .up_valid(upd_valid_i), .up_addr(upd_addr_i),
        .up_target(upd_target_i), .up_taken(upd_taken_i),
        .hit(hit_o), .taken(pred_taken_o), .target(pred_target_o)
    );

    static_pred #(.ADDR_W(ADDR_W)) u_static (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid_i), .dec_addr(dec_addr_i), .dec_disp(dec_disp_i),
        .st_valid(st_valid_o), .st_taken(st_taken_o), .st_target(st_target_o)
    );

    ret_stack #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_ras (
        .clk(clk), .rst_n(rst_n),
        .push(call_push_i), .push_addr(call_ret_addr_i), .pop(ret_pop_i),
        .pop_valid(ras_valid_o), .pop_err(ras_err_o), .pop_target(ras_target_o)
    );
endmodule

// File: rtl/branch_oracle_chk.sv
module branch_oracle_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid_i,
    input logic              dec_valid_i,
    input logic [ADDR_W-1:0] dec_disp_i,
    input logic              ret_pop_i,
    input logic              hit_o,
    input logic              pred_taken_o,
    input logic              st_valid_o,
    input logic              st_taken_o,
    input logic              ras_valid_o,
    input logic              ras_err_o
);
    assert_no_spurious_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid_i |=> !hit_o);

    assert_taken_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken_o |-> hit_o);

    assert_static_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> (st_valid_o && st_taken_o == $past(dec_disp_i[ADDR_W-1])));

    assert_pop_result_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ras_valid_o && ras_err_o));

    assert_no_pop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_pop_i |=> (!ras_valid_o && !ras_err_o));

    assert_pop_answers_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ret_pop_i |=> $countones({ras_valid_o, ras_err_o}) == 1);
endmodule

bind branch_oracle branch_oracle_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .lk_valid_i(lk_valid_i), .dec_valid_i(dec_valid_i), .dec_disp_i(dec_disp_i),
    .ret_pop_i(ret_pop_i), .hit_o(hit_o), .pred_taken_o(pred_taken_o),
    .st_valid_o(st_valid_o), .st_taken_o(st_taken_o),
    .ras_valid_o(ras_valid_o), .ras_err_o(ras_err_o)
);

// File: tb/branch_oracle_tb_top.sv
module branch_oracle_tb_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_v, up_v, up_k, dv, push, pop;
    logic [AW-1:0] lk_a, up_a, up_t, dpc, ddisp, paddr;
    logic          hit, ptk, sv, stk, rv, rerr;
    logic [AW-1:0] ptgt, stgt, rtgt;

    always #5 clk = ~clk;

    branch_oracle #(.ADDR_W(AW), .IDX_W(4), .TAG_W(8), .RAS_DEPTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid_i(lk_v), .lk_addr_i(lk_a),
        .upd_valid_i(up_v), .upd_addr_i(up_a), .upd_target_i(up_t), .upd_taken_i(up_k),
        .dec_valid_i(dv), .dec_addr_i(dpc), .dec_disp_i(ddisp),
        .call_push_i(push), .call_ret_addr_i(paddr), .ret_pop_i(pop),
        .hit_o(hit), .pred_taken_o(ptk), .pred_target_o(ptgt),
        .st_valid_o(sv), .st_taken_o(stk), .st_target_o(stgt),
        .ras_valid_o(rv), .ras_err_o(rerr), .ras_target_o(rtgt)
    );

    typedef struct {
        logic          hit, tk, sv, stk, rv, rerr;
        logic [AW-1:0] tgt, stgt, rtgt;
        string         req;
    } exp_t;

    exp_t scb[$];
    int   n_vec = 0;
    int   n_bad = 0;

    function automatic exp_t quiet(string r);
        exp_t e;
        e.hit = 0; e.tk = 0; e.sv = 0; e.stk = 0; e.rv = 0; e.rerr = 0;
        e.tgt = '0; e.stgt = '0; e.rtgt = '0; e.req = r;
        return e;
    endfunction

    task automatic idle_inputs();
        lk_v = 0; lk_a = '0; up_v = 0; up_a = '0; up_t = '0; up_k = 0;
        dv = 0; dpc = '0; ddisp = '0; push = 0; paddr = '0; pop = 0;
    endtask

    // inputs must be set by the caller before calling commit
    task automatic commit(exp_t e);
        scb.push_back(e);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic lk(logic [AW-1:0] a, logic h, logic t, logic [AW-1:0] g, string r);
        exp_t e = quiet(r);
        lk_v = 1; lk_a = a;
        e.hit = h; e.tk = t; e.tgt = g;
        commit(e);
    endtask

    task automatic up(logic [AW-1:0] a, logic [AW-1:0] g, logic t, string r);
        up_v = 1; up_a = a; up_t = g; up_k = t;
        commit(quiet(r));
    endtask

    task automatic dec(logic [AW-1:0] a, logic [AW-1:0] d, logic t, logic [AW-1:0] g, string r);
        exp_t e = quiet(r);
        dv = 1; dpc = a; ddisp = d;
        e.sv = 1; e.stk = t; e.stgt = g;
        commit(e);
    endtask

    task automatic psh(logic [AW-1:0] a, string r);
        push = 1; paddr = a;
        commit(quiet(r));
    endtask

    task automatic pp(logic v, logic er, logic [AW-1:0] g, string r);
        exp_t e = quiet(r);
        pop = 1;
        e.rv = v; e.rerr = er; e.rtgt = g;
        commit(e);
    endtask

    task automatic compare(exp_t e);
        n_vec++;
        if (hit !== e.hit || ptk !== e.tk || ptgt !== e.tgt || sv !== e.sv || stk !== e.stk ||
            stgt !== e.stgt || rv !== e.rv || rerr !== e.rerr || rtgt !== e.rtgt) begin
            n_bad++;
            $display("FAIL %s: got hit=%b tk=%b tgt=%h sv=%b stk=%b stgt=%h rv=%b err=%b rtgt=%h ; exp hit=%b tk=%b tgt=%h sv=%b stk=%b stgt=%h rv=%b err=%b rtgt=%h",
                     e.req, hit, ptk, ptgt, sv, stk, stgt, rv, rerr, rtgt,
                     e.hit, e.tk, e.tgt, e.sv, e.stk, e.stgt, e.rv, e.rerr, e.rtgt);
        end
    endtask

    // monitor: results of the inputs driven at the last falling edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (scb.size() > 0) compare(scb.pop_front());
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout, exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        exp_t e;
        idle_inputs();
        repeat (3) @(negedge clk);
        compare(quiet("R1 outputs in reset"));
        rst_n = 1;
        @(negedge clk);
        compare(quiet("R1 outputs after reset"));

        // table: allocation, counter, aliasing
        lk(32'h100, 0, 0, '0, "R1 R2 lookup misses after reset");
        up(32'h100, 32'h200, 1, "R3 alloc taken");
        lk(32'h100, 1, 1, 32'h200, "R3 weak taken predicts taken");
        up(32'h100, 32'h200, 1, "R4 inc");
        up(32'h100, 32'h200, 1, "R4 saturate");
        up(32'h100, 32'h200, 1, "R4 stays at 3");
        up(32'h100, 32'h200, 0, "R4 dec to 2");
        lk(32'h100, 1, 1, 32'h200, "R4 counter 2 still taken");
        up(32'h100, 32'h240, 0, "R4 dec to 1");
        lk(32'h100, 1, 0, 32'h240, "R4 counter 1 not taken, new target");
        up(32'h344, 32'h50, 0, "R3 alloc not taken");
        lk(32'h344, 1, 0, 32'h50, "R3 weak not-taken predicts not taken");
        lk(32'h444, 0, 0, '0, "R5 same index other tag misses");

        // same-cycle lookup and update
        e = quiet("R6 lookup sees old entry");
        lk_v = 1; lk_a = 32'h344;
        up_v = 1; up_a = 32'h344; up_t = 32'h60; up_k = 1;
        e.hit = 1; e.tk = 0; e.tgt = 32'h50;
        commit(e);
        lk(32'h344, 1, 1, 32'h60, "R6 next lookup sees update");

        up(32'h444, 32'h70, 1, "R5 replace entry");
        lk(32'h344, 0, 0, '0, "R5 old address misses");
        lk(32'h444, 1, 1, 32'h70, "R5 new address hits");
        lk(32'h500, 0, 0, '0, "R12 miss");
        lk(32'h500, 0, 0, '0, "R12 lookup did not allocate");

        // static fallback
        dec(32'h1000, -32'sd16, 1, 32'h0FF0, "R7 backward taken");
        dec(32'h1000, 32'd32, 0, 32'h1020, "R7 forward not taken");
        dec(32'h1000, 32'd0, 0, 32'h1000, "R7 zero displacement not taken");

        // return stack
        pp(0, 1, '0, "R10 pop on empty");
        psh(32'hA, "R8 push");
        psh(32'hB, "R8 push");
        pp(1, 0, 32'hB, "R8 pop newest");
        pp(1, 0, 32'hA, "R8 pop older");
        pp(0, 1, '0, "R10 empty again");
        for (int i = 1; i <= 5; i++) psh(AW'(i), "R9 push");
        for (int i = 5; i >= 2; i--) pp(1, 0, AW'(i), "R9 pop after overflow");
        pp(0, 1, '0, "R9 oldest lost");
        psh(32'h11, "R11 push");
        e = quiet("R11 combined returns top");
        push = 1; paddr = 32'h22; pop = 1;
        e.rv = 1; e.rtgt = 32'h11;
        commit(e);
        pp(1, 0, 32'h22, "R11 pushed address replaced top");
        pp(0, 1, '0, "R11 depth unchanged");

        // mixed traffic in one cycle
        e = quiet("R2 R7 R8 concurrent paths");
        lk_v = 1; lk_a = 32'h444; dv = 1; dpc = 32'h80; ddisp = -32'sd8; pop = 1;
        e.hit = 1; e.tk = 1; e.tgt = 32'h70; e.sv = 1; e.stk = 1; e.stgt = 32'h78; e.rerr = 1;
        commit(e);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule